// File: doc/BRIEF.md
# Programmable Pulse Train Generator

This block drives one output as an endless train of pulses. The high time of each pulse and the low gap between pulses are set at run time. A single 8-bit data input carries both settings. Two separate strobes select which setting the data goes into: one loads the pulse width and the other loads the gap.

Inside there are two setting registers, one shared down-counter and a two-phase controller. At each phase boundary the counter reloads from the setting of the phase that is starting, and the output register changes level. A new setting does not shorten or lengthen the phase that is already running. It takes effect the next time its own phase starts. A setting of zero gives a one-cycle phase, so the output never stops toggling.

Top module: `pulse_gen`

## Requirements
- R1: When `ld_width` is high at a rising clock edge, the width register captures the 8-bit value on `data_in`.
- R2: When `ld_gap` is high at a rising clock edge, the gap register captures the 8-bit value on `data_in`.
- R3: If `ld_width` and `ld_gap` are both high in the same cycle, both registers capture the same `data_in` value.
- R4: Each high phase of `pulse_out` lasts exactly W clock cycles, where W is the width setting (W = 1 to 255).
- R5: Each low phase of `pulse_out` lasts exactly G clock cycles, where G is the gap setting (G = 1 to 255).
- R6: A setting of 0 makes its phase last exactly 1 cycle.
- R7: `pulse_out` alternates without end: a high phase, then a low phase, then a high phase, and so on.
- R8: `rst` is synchronous and active high. It clears both settings and the counter, and it holds `pulse_out` at 0 in the low phase. The first rising edge after `rst` is released starts a high phase.
- R9: A setting loaded while a phase is running does not change the length of that phase. The new value is used from the next start of its own phase. A load that is captured at the same edge where its phase starts is not used for that phase; the phase runs with the old value.
- R10: `pulse_out` comes directly from a flip-flop and only changes at a phase boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 8 | Setting value shared by both loads |
| ld_width | input | 1 | Loads `data_in` into the pulse-width register |
| ld_gap | input | 1 | Loads `data_in` into the inter-pulse gap register |
| pulse_out | output | 1 | Registered pulse train |

## Verification
Two events can fall in the same cycle: a setting load and the phase boundary that reads that same setting. The bench provokes this by driving a width load during the last low cycle, so the register is written at the same edge where the counter reloads for the new high phase. The check passes only if that high phase keeps the old length and the following high phase uses the new one. Loading both strobes in one cycle and loading a new width partway through a long pulse are also measured, by counting the high and low run lengths at the output.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_t;

  // A phase of length N needs N-1 as the counter start; 0 and 1 both mean one cycle
  function automatic logic [7:0] start_count(input logic [7:0] setting);
    return (setting == 8'd0) ? 8'd0 : setting - 8'd1;
  endfunction
endpackage

// File: rtl/pgen_setting_reg.sv
module pgen_setting_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end

  // R1 R2
  ld_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> q == $past(d));
endmodule

// File: rtl/pgen_downcounter.sv
module pgen_downcounter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] reload_val,
  output logic          at_end
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == '0)   cnt <= reload_val;
    else                  cnt <= cnt - 1'b1;
  end

  assign at_end = (cnt == '0);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pgen_phase_ctrl.sv
module pgen_phase_ctrl
  import pgen_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   at_end,
  output phase_t phase
);
  always_ff @(posedge clk) begin
    if (rst)         phase <= PH_LOW;
    else if (at_end) phase <= (phase == PH_HIGH) ? PH_LOW : PH_HIGH;
  end

  // R7
  phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
    at_end |=> (phase != $past(phase)));

  // R10
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !at_end |=> $stable(phase));
endmodule

// File: rtl/pulse_gen.sv
module pulse_gen
  import pgen_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] data_in,
  input  logic          ld_width,
  input  logic          ld_gap,
  output logic          pulse_out
);
  localparam int NSET   = 2;
  localparam int IDX_W  = 0;
  localparam int IDX_G  = 1;

  logic [NSET-1:0] ld_vec;
  logic [DW-1:0]   set_q [NSET];
  logic [DW-1:0]   next_setting;
  logic [DW-1:0]   reload_val;
  logic            at_end;
  phase_t          phase;

  assign ld_vec[IDX_W] = ld_width;
  assign ld_vec[IDX_G] = ld_gap;

  for (genvar i = 0; i < NSET; i++) begin : g_set
    pgen_setting_reg #(.DW(DW)) u_reg (
      .clk (clk),
      .rst (rst),
      .ld  (ld_vec[i]),
      .d   (data_in),
      .q   (set_q[i])
    );
  end

  // Reload picks the setting of the phase about to start
  assign next_setting = (phase == PH_HIGH) ? set_q[IDX_G] : set_q[IDX_W];
  assign reload_val   = (next_setting == '0) ? '0 : next_setting - 1'b1;

  pgen_downcounter #(.DW(DW)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .reload_val (reload_val),
    .at_end     (at_end)
  );

  pgen_phase_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .at_end (at_end),
    .phase  (phase)
  );

  assign pulse_out = (phase == PH_HIGH);
endmodule

// File: tb/test_pulse_gen.sv
module test_pulse_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] data_in = '0;
  logic       ld_width = 1'b0;
  logic       ld_gap = 1'b0;
  logic       pulse_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pulse_gen i_pulse_gen (
    .clk       (clk),
    .rst       (rst),
    .data_in   (data_in),
    .ld_width  (ld_width),
    .ld_gap    (ld_gap),
    .pulse_out (pulse_out)
  );

  localparam int NVEC = 7;
  // {width setting, gap setting}
  localparam int VEC [NVEC][2] = '{
    '{1, 1}, '{2, 3}, '{7, 4}, '{0, 5}, '{9, 0}, '{255, 2}, '{3, 200}
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load(input logic w, input logic g, input int val);
    @(negedge clk);
    data_in = val[7:0]; ld_width = w; ld_gap = g;
    @(negedge clk);
    ld_width = 1'b0; ld_gap = 1'b0;
  endtask

  task automatic sync_high();
    while (pulse_out === 1'b1) @(negedge clk);
    while (pulse_out !== 1'b1) @(negedge clk);
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (pulse_out === lvl && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    // R8: reset state
    @(negedge clk); @(negedge clk);
    check("R8 output low in reset", pulse_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 first edge after reset starts high", pulse_out, 1);
    @(negedge clk);
    check("R6 cleared width gives 1 cycle", pulse_out, 0);
    @(negedge clk);
    check("R6 cleared gap gives 1 cycle", pulse_out, 1);

    // R1 R2 R4 R5 R6 R7: vector table
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      load(1'b1, 1'b0, VEC[i][0]);
      load(1'b0, 1'b1, VEC[i][1]);
      sync_high();
      run_len(1'b1, n); check("R1 R4 R6 high length", n, eff(VEC[i][0]));
      run_len(1'b0, n); check("R2 R5 R6 low length", n, eff(VEC[i][1]));
      run_len(1'b1, n); check("R7 repeat high length", n, eff(VEC[i][0]));
    end

    // R3: both strobes in one cycle
    do_reset();
    load(1'b1, 1'b1, 5);
    sync_high();
    run_len(1'b1, n); check("R3 width from shared load", n, 5);
    run_len(1'b0, n); check("R3 gap from shared load", n, 5);

    // R9: width change in the middle of a high phase
    do_reset();
    load(1'b1, 1'b0, 20);
    load(1'b0, 1'b1, 4);
    sync_high();
    n = 0;
    repeat (5) begin n++; @(negedge clk); end
    data_in = 8'd3; ld_width = 1'b1;
    @(negedge clk); n++;
    ld_width = 1'b0;
    while (pulse_out === 1'b1 && n < 1000) begin n++; @(negedge clk); end
    check("R9 running high not cut short", n, 20);
    run_len(1'b0, n); check("R9 gap unchanged", n, 4);
    run_len(1'b1, n); check("R9 new width used next", n, 3);

    // R9: load captured at the same edge the high phase starts
    do_reset();
    load(1'b1, 1'b0, 6);
    load(1'b0, 1'b1, 2);
    sync_high();
    run_len(1'b1, n); check("R4 high before boundary load", n, 6);
    @(negedge clk);
    check("R5 second low cycle", pulse_out, 0);
    data_in = 8'd2; ld_width = 1'b1;
    @(negedge clk);
    ld_width = 1'b0;
    run_len(1'b1, n); check("R9 boundary load keeps old width", n, 6);
    run_len(1'b0, n); check("R5 gap after boundary load", n, 2);
    run_len(1'b1, n); check("R9 boundary load used next phase", n, 2);

    // R8: reset in the middle of a long pulse
    load(1'b1, 1'b0, 50);
    sync_high();
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset forces low mid pulse", pulse_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 high after reset release", pulse_out, 1);
    run_len(1'b1, n); check("R8 width cleared by reset", n, 1);
    run_len(1'b0, n); check("R8 gap cleared by reset", n, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule